// File: doc/BRIEF.md
# Clock Page Replacement Selector

This block chooses which page frame gets the next incoming page, using the clock (second-chance) method over a fixed set of frames. For each frame it keeps a use bit and a lock bit. A circular hand pointer marks where the next search starts. The use bit of a frame is set whenever its page is referenced or a new page is loaded into it. Lock commands pin a frame so that it can never be evicted.

A replacement request starts a scan at the hand, and the scan inspects one frame per clock cycle. An unlocked frame whose use bit is set gets a second chance: its bit is cleared and the hand moves on. Locked frames are stepped over and left untouched. The first unlocked frame found with a clear use bit becomes the victim. The block then reports the victim with a one-cycle done strobe, marks it used because the new page goes there, and parks the hand on the frame after it.

If every frame is locked, the request ends at once with a one-cycle failure strobe and nothing else changes. Requests that arrive while a scan is in progress are dropped.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset all use bits and lock bits are clear, the hand is at frame 0, and busy, done and fail are low; the first request therefore picks frame 0.
- R2: A reference event (ref_valid with ref_frame) sets that frame's use bit, so the next scan passes over it once instead of choosing it.
- R3: A load event (load_valid with load_frame) sets that frame's use bit in the same way as a reference.
- R4: A scan starts at the hand and picks the first unlocked frame whose use bit is 0. It clears the use bit of every unlocked frame it passes whose bit is 1.
- R5: After a victim v is chosen the hand is at (v+1) mod 8, and the next scan starts there.
- R6: When every unlocked frame has its use bit set, the scan goes once round the circle clearing them and picks the frame where it started.
- R7: A locked frame (lock_valid with lock_set=1) is never chosen and its use bit is not changed by a scan. lock_set=0 unlocks the frame.
- R8: If all 8 frames are locked when a request is taken, fail pulses for one cycle on the next cycle, done stays low, and the hand and use bits are left unchanged.
- R9: A reference or load to the frame under inspection in the same cycle takes priority over the clear. That frame is passed with its use bit left set.
- R10: The chosen victim's use bit is set to 1 when it is chosen.
- R11: done is a one-cycle pulse with victim valid in that cycle. When no events touch the frames during the scan, done comes at most 9 cycles after the request is taken.
- R12: req_valid is ignored while busy is high. It produces no extra result.
- R13: After a failed request, unlocking frames lets the next request succeed from the unchanged hand position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_valid | input | 1 | Reference event strobe |
| ref_frame | input | 3 | Frame referenced |
| load_valid | input | 1 | Load event strobe |
| load_frame | input | 3 | Frame receiving a page |
| lock_valid | input | 1 | Lock command strobe |
| lock_frame | input | 3 | Frame targeted by lock command |
| lock_set | input | 1 | 1 locks the frame, 0 unlocks it |
| req_valid | input | 1 | Replacement request |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Victim found, one-cycle pulse |
| fail | output | 1 | All frames locked, one-cycle pulse |
| victim | output | 3 | Index of chosen frame, valid with done |

## Verification
The assertions assume that lock commands do not arrive while a scan runs, and that references and loads do not keep re-marking frames fast enough to stall a scan. The scan-length bound and the latency figure both depend on these two conditions. The stimulus issues references, loads and lock changes only between requests. The one exception is a single reference aimed at the frame under inspection in the first scan cycle, which exercises the priority rule.

// File: rtl/clkrep_pkg.sv
package clkrep_pkg;
  typedef enum logic {
    S_IDLE = 1'b0,
    S_SCAN = 1'b1
  } scan_state_t;
endpackage

// File: rtl/clkrep_flags.sv
// Per-frame use and lock bits. Reference and load events and the winner
// mark take priority over the scan's second-chance clear.
module clkrep_flags #(
  parameter int NF = 8,
  parameter int IW = $clog2(NF)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ref_v,
  input  logic [IW-1:0] ref_idx,
  input  logic          load_v,
  input  logic [IW-1:0] load_idx,
  input  logic          lk_v,
  input  logic [IW-1:0] lk_idx,
  input  logic          lk_set,
  input  logic          clr_v,
  input  logic [IW-1:0] clr_idx,
  input  logic          win_v,
  input  logic [IW-1:0] win_idx,
  output logic [NF-1:0] use_vec,
  output logic [NF-1:0] lock_vec,
  output logic [NF-1:0] evt_vec
);
  for (genvar i = 0; i < NF; i++) begin : g_frame
    logic touch;
    logic mark;
    assign touch = (ref_v && ref_idx == IW'(i)) || (load_v && load_idx == IW'(i));
    assign mark  = touch || (win_v && win_idx == IW'(i));
    assign evt_vec[i] = touch;

    always_ff @(posedge clk) begin
      if (rst) begin
        use_vec[i] <= 1'b0;
      end else if (mark) begin
        use_vec[i] <= 1'b1;
      end else if (clr_v && clr_idx == IW'(i)) begin
        use_vec[i] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        lock_vec[i] <= 1'b0;
      end else if (lk_v && lk_idx == IW'(i)) begin
        lock_vec[i] <= lk_set;
      end
    end
  end
endmodule

// File: rtl/clkrep_hand.sv
// Hand pointer and scan controller: one frame inspected per cycle.
module clkrep_hand
  import clkrep_pkg::*;
#(
  parameter int NF = 8,
  parameter int IW = $clog2(NF)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic [NF-1:0] use_vec,
  input  logic [NF-1:0] lock_vec,
  input  logic [NF-1:0] evt_vec,
  output logic          clr_v,
  output logic [IW-1:0] clr_idx,
  output logic          win_v,
  output logic [IW-1:0] win_idx,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic [IW-1:0] victim,
  output logic [IW-1:0] hand
);
  localparam int SW = IW + 2;

  scan_state_t   st;
  logic [SW-1:0] steps;
  logic          all_locked;
  logic          cur_lock;
  logic          cur_used;
  logic [IW-1:0] hand_nxt;

  assign all_locked = &lock_vec;
  assign cur_lock   = lock_vec[hand];
  assign cur_used   = use_vec[hand] | evt_vec[hand];
  assign hand_nxt   = (hand == IW'(NF - 1)) ? '0 : hand + 1'b1;
  assign busy       = (st == S_SCAN);
  assign clr_idx    = hand;
  assign win_idx    = hand;

  always_comb begin
    clr_v = 1'b0;
    win_v = 1'b0;
    if (st == S_SCAN && !all_locked && !cur_lock) begin
      if (cur_used) clr_v = !evt_vec[hand];
      else          win_v = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      hand   <= '0;
      done   <= 1'b0;
      fail   <= 1'b0;
      victim <= '0;
      steps  <= '0;
    end else begin
      done <= 1'b0;
      fail <= 1'b0;
      unique case (st)
        S_IDLE: begin
          steps <= '0;
          if (req) begin
            if (all_locked) fail <= 1'b1;
            else            st   <= S_SCAN;
          end
        end
        S_SCAN: begin
          steps <= steps + 1'b1;
          if (all_locked) begin
            fail <= 1'b1;
            st   <= S_IDLE;
          end else if (cur_lock || cur_used) begin
            hand <= hand_nxt;
          end else begin
            victim <= hand;
            done   <= 1'b1;
            hand   <= hand_nxt;
            st     <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R5: hand parks just after the victim
  a_r5_hand_after_victim: assert property (@(posedge clk) disable iff (rst)
    done |-> hand == ((victim == IW'(NF - 1)) ? '0 : victim + 1'b1));
  // R8: failed request leaves the hand where it was
  a_r8_hand_kept: assert property (@(posedge clk) disable iff (rst)
    fail |-> $stable(hand));
  // R11: strobes are single-cycle and exclusive
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r11_no_both: assert property (@(posedge clk) disable iff (rst)
    !(done && fail));
  // R11: scan length stays bounded
  a_r11_scan_bound: assert property (@(posedge clk) disable iff (rst)
    busy |-> int'(steps) <= 2 * NF);
  // R12: a result ends the scan
  a_r12_idle_on_result: assert property (@(posedge clk) disable iff (rst)
    (done || fail) |-> !busy);
endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel #(
  parameter int NUM_FRAMES = 8,
  parameter int IDX_W      = $clog2(NUM_FRAMES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_valid,
  input  logic [IDX_W-1:0] ref_frame,
  input  logic             load_valid,
  input  logic [IDX_W-1:0] load_frame,
  input  logic             lock_valid,
  input  logic [IDX_W-1:0] lock_frame,
  input  logic             lock_set,
  input  logic             req_valid,
  output logic             busy,
  output logic             done,
  output logic             fail,
  output logic [IDX_W-1:0] victim
);
  logic [NUM_FRAMES-1:0] use_vec;
  logic [NUM_FRAMES-1:0] lock_vec;
  logic [NUM_FRAMES-1:0] evt_vec;
  logic                  clr_v;
  logic [IDX_W-1:0]      clr_idx;
  logic                  win_v;
  logic [IDX_W-1:0]      win_idx;
  logic [IDX_W-1:0]      hand;

  clkrep_flags #(.NF(NUM_FRAMES), .IW(IDX_W)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .ref_v    (ref_valid),
    .ref_idx  (ref_frame),
    .load_v   (load_valid),
    .load_idx (load_frame),
    .lk_v     (lock_valid),
    .lk_idx   (lock_frame),
    .lk_set   (lock_set),
    .clr_v    (clr_v),
    .clr_idx  (clr_idx),
    .win_v    (win_v),
    .win_idx  (win_idx),
    .use_vec  (use_vec),
    .lock_vec (lock_vec),
    .evt_vec  (evt_vec)
  );

  clkrep_hand #(.NF(NUM_FRAMES), .IW(IDX_W)) u_hand (
    .clk      (clk),
    .rst      (rst),
    .req      (req_valid),
    .use_vec  (use_vec),
    .lock_vec (lock_vec),
    .evt_vec  (evt_vec),
    .clr_v    (clr_v),
    .clr_idx  (clr_idx),
    .win_v    (win_v),
    .win_idx  (win_idx),
    .busy     (busy),
    .done     (done),
    .fail     (fail),
    .victim   (victim),
    .hand     (hand)
  );

  // R10: victim frame is marked used once chosen
  a_r10_victim_marked: assert property (@(posedge clk) disable iff (rst)
    done |-> use_vec[victim]);
  // R7: a frame locked at inspection time is never reported
  a_r7_never_locked: assert property (@(posedge clk) disable iff (rst)
    done |-> (($past(lock_vec) >> victim) & NUM_FRAMES'(1)) == '0);
  // R8: fail only when every frame was locked
  a_r8_fail_all_locked: assert property (@(posedge clk) disable iff (rst)
    fail |-> &($past(lock_vec)));
  // R8: use bits untouched by a failed request
  a_r8_use_kept: assert property (@(posedge clk) disable iff (rst)
    (fail && !$past(ref_valid) && !$past(load_valid)) |-> $stable(use_vec));
endmodule

// File: tb/sim_clock_victim_sel.sv
module sim_clock_victim_sel;
  localparam int NF = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst = 1'b1;
  logic          ref_valid = 1'b0, load_valid = 1'b0, lock_valid = 1'b0;
  logic          lock_set = 1'b0, req_valid = 1'b0;
  logic [IW-1:0] ref_frame = '0, load_frame = '0, lock_frame = '0;
  logic          busy, done, fail;
  logic [IW-1:0] victim;

  clock_victim_sel #(.NUM_FRAMES(NF), .IDX_W(IW)) u0 (
    .clk(clk), .rst(rst),
    .ref_valid(ref_valid), .ref_frame(ref_frame),
    .load_valid(load_valid), .load_frame(load_frame),
    .lock_valid(lock_valid), .lock_frame(lock_frame), .lock_set(lock_set),
    .req_valid(req_valid),
    .busy(busy), .done(done), .fail(fail), .victim(victim)
  );

  typedef struct {
    bit    is_fail;
    int    frame;
    int    start;
    string req;
  } exp_t;

  exp_t q[$];
  int   total = 0, bad = 0, resp_cnt = 0, cyc = 0;
  bit   m_use[NF];
  bit   m_lock[NF];
  int   m_hand = 0;
  bit   finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string r, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  // monitor: pops expected results as done/fail appear
  always @(negedge clk) begin
    if (!rst && (done || fail)) begin
      if (q.size() == 0) begin
        chk(0, "R12", "unexpected result strobe", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(fail == e.is_fail, e.req, "fail flag", int'(fail), int'(e.is_fail));
        if (!e.is_fail)
          chk(int'(victim) == e.frame, e.req, "victim", int'(victim), e.frame);
        chk(cyc - e.start <= NF + 1, "R11", "latency", cyc - e.start, NF + 1);
      end
      resp_cnt++;
    end
  end

  // reference model of the clock rule
  task automatic model_pick(bit touch, output exp_t e);
    int  h;
    bit  all_lk;
    all_lk = 1;
    for (int i = 0; i < NF; i++) if (!m_lock[i]) all_lk = 0;
    e.is_fail = all_lk;
    e.frame   = -1;
    if (all_lk) return;
    h = m_hand;
    if (touch) m_use[h] = 1;
    for (int s = 0; s < 4 * NF; s++) begin
      if (m_lock[h]) begin
      end else if (touch && s == 0) begin
      end else if (m_use[h]) begin
        m_use[h] = 0;
      end else begin
        e.frame  = h;
        m_use[h] = 1;
        m_hand   = (h + 1) % NF;
        return;
      end
      h = (h + 1) % NF;
    end
  endtask

  task automatic ev_ref(int f);
    @(negedge clk); ref_valid = 1; ref_frame = IW'(f);
    @(negedge clk); ref_valid = 0;
    m_use[f] = 1;
  endtask

  task automatic ev_load(int f);
    @(negedge clk); load_valid = 1; load_frame = IW'(f);
    @(negedge clk); load_valid = 0;
    m_use[f] = 1;
  endtask

  task automatic set_lock(int f, bit v);
    @(negedge clk); lock_valid = 1; lock_frame = IW'(f); lock_set = v;
    @(negedge clk); lock_valid = 0;
    m_lock[f] = v;
  endtask

  // driver: touch = reference the hand frame in the first scan cycle,
  // extra = pulse req again while busy
  task automatic do_req(string r, bit touch, bit extra);
    exp_t e;
    int   target;
    int   h0;
    h0 = m_hand;
    model_pick(touch, e);
    @(negedge clk);
    e.start = cyc + 1;
    e.req   = r;
    q.push_back(e);
    target = resp_cnt + 1;
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    if (touch) begin
      ref_valid = 1; ref_frame = IW'(h0);
      @(negedge clk); ref_valid = 0;
    end
    if (extra) begin
      req_valid = 1;
      @(negedge clk); req_valid = 0;
    end
    while (resp_cnt != target) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NF; i++) begin m_use[i] = 0; m_lock[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(busy == 0, "R1", "busy after reset", int'(busy), 0);
    chk(done == 0, "R1", "done after reset", int'(done), 0);
    chk(fail == 0, "R1", "fail after reset", int'(fail), 0);

    do_req("R1", 0, 0);                 // frame 0
    do_req("R4", 0, 0);                 // frame 1
    do_req("R5", 0, 0);                 // frame 2
    ev_ref(3); ev_ref(4);
    do_req("R2", 0, 0);                 // passes 3,4 -> 5
    ev_load(6);
    do_req("R3", 0, 0);                 // passes 6 -> 7
    do_req("R4", 0, 0);
    do_req("R5", 0, 0);

    for (int i = 0; i < NF; i++) ev_load(i);
    do_req("R6", 0, 0);                 // full circle
    do_req("R10", 0, 0);

    set_lock(m_hand, 1);
    set_lock((m_hand + 1) % NF, 1);
    ev_ref((m_hand + 5) % NF);
    for (int k = 0; k < 10; k++) do_req("R7", 0, 0);
    set_lock(2, 0);
    do_req("R7", 0, 0);

    for (int i = 0; i < NF; i++) set_lock(i, 1);
    do_req("R8", 0, 0);
    do_req("R8", 0, 0);
    set_lock(5, 0);
    set_lock(1, 0);
    do_req("R13", 0, 0);
    for (int i = 0; i < NF; i++) set_lock(i, 0);
    do_req("R13", 0, 0);

    do_req("R9", 1, 0);
    do_req("R9", 0, 0);

    do_req("R12", 0, 1);
    repeat (12) @(negedge clk);
    chk(busy == 0, "R12", "busy after ignored request", int'(busy), 0);
    chk(q.size() == 0, "R12", "pending results", q.size(), 0);
    do_req("R12", 0, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule